// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Break Handling

This block turns a single asynchronous serial line into framed characters. It works from a 16x oversampling tick supplied from outside, and it synchronizes the raw line itself through two flops. When a falling edge is seen, the block confirms the start bit near its middle. It then samples each data bit, the optional parity bit and the stop bit at the bit centres. It hands each character on with its parity-error, framing-error and break flags in a single-cycle write strobe to whatever receive buffer follows it.

Two line conditions get special treatment. The first is a character that is not all zero and whose stop bit is low. It is delivered with a framing error, and the block checks the line again half a bit after the stop sample. If the line is still low there, that point counts as a newly detected start bit. The second is a character that is low for its whole length, stop bit included. It is delivered as an all-zero byte with the break flag set, and it sets a sticky change-of-break flag. The receiver then waits until the line has been seen high on two consecutive oversampling ticks before it hunts for a start bit again. The sticky flag stays set until a clear command arrives.

Top module: `serial_char_rx`

## Requirements
- R1: After the first tick that sees the synchronized line low following a high tick, the line is checked again 7 ticks later. If it is high at that check, no character is produced and hunting resumes.
- R2: Data bits are taken every 16 ticks after the start check, least significant bit first. The length select `len_sel` gives 5 + len_sel data bits (0 gives 5, 3 gives 8). Data bits above the character length read as zero.
- R3: With `par_en` set, one parity bit follows the data bits. With `par_odd` = 0, the data bits plus the parity bit must hold an even number of ones; with `par_odd` = 1, an odd number. A mismatch sets `char_perr`.
- R4: A high stop bit produces `char_wr` for exactly one cycle, with `char_ferr` and `char_brk` both 0. Hunting for the next start bit begins on the next tick, so back-to-back characters are all received.
- R5: A low stop bit sets `char_ferr` when any data bit, or the parity bit when it is enabled, was 1.
- R6: After a framing error, the line is checked 8 ticks after the stop sample. If it is low, that tick counts as a start-bit detection (the R1 check follows 7 ticks later). If it is high, the block returns to hunting.
- R7: A frame that is low in every bit, stop bit included, is delivered as `char_data` = 0 with `char_brk` = 1, `char_ferr` = 0 and `char_perr` = 0.
- R8: After a break, no start bit is accepted until the line has been high on two consecutive ticks. A single high tick followed by a low line is ignored.
- R9: `brk_chg` goes to 1 in the cycle the break character is strobed and holds until `brk_chg_clr` is sampled high. If a break and a clear arrive on the same edge, the break wins.
- R10: While `rx_en` is low, no character is produced and any frame in progress is dropped. After enable, the line must be seen high before a start bit is accepted.
- R11: After reset, `char_wr` and `brk_chg` are 0. A line that is low when reset ends is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receiver enable |
| rx_line | input | 1 | Raw serial input, idle high |
| len_sel | input | 2 | Character length: 5 + len_sel data bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| brk_chg_clr | input | 1 | Clears the change-of-break flag |
| char_wr | output | 1 | One-cycle strobe for a received character |
| char_data | output | 8 | Received character, zero-filled above its length |
| char_perr | output | 1 | Parity error for this character |
| char_ferr | output | 1 | Framing error for this character |
| char_brk | output | 1 | This character is a break |
| brk_chg | output | 1 | Sticky change-of-break flag |

## Verification
The break character's write strobe and the change-of-break clear command can land on the same clock edge. The bench provokes this by holding the clear high for the whole of a break frame, so the clear is present on the exact edge where the break is recorded. The result is judged by the flag being visible in the same cycle as the break strobe and being gone one cycle later, and a cycle-by-cycle reference model confirms both cycles. A framing error followed by a low line also lands the resynchronisation point on the tick right next to where the next frame's start edge is driven. The character that follows must be decoded correctly.

// File: rtl/srx_pkg.sv
// Package: shared types for the serial character receiver.
// Assumes: frames are at most DATA_W data bits, one parity bit and one stop bit.
package srx_pkg;

    // Receiver sequencing states
    typedef enum logic [2:0] {
        ST_HUNT    = 3'd0,
        ST_START   = 3'd1,
        ST_BITS    = 3'd2,
        ST_FEHOLD  = 3'd3,
        ST_BRKWAIT = 3'd4
    } srx_state_e;

    // How a completed frame ended
    typedef enum logic [1:0] {
        END_OK    = 2'd0,
        END_FRAME = 2'd1,
        END_BREAK = 2'd2
    } srx_end_e;

endpackage

// File: rtl/srx_sync.sv
// Module: srx_sync
// Brings the asynchronous serial line into the clock domain through a chain of
// STAGES flops. Assumes: idle level is high, so every stage resets to 1.
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= din;
            for (int k = 1; k < STAGES; k++) begin
                chain[k] <= chain[k-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_frame_chk.sv
// Module: srx_frame_chk
// Classifies a completed frame as normal, framing error or break, and checks parity.
// Assumes: data bits above the active length are already zero.
module srx_frame_chk
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              par_bit,
    input  logic              stop_bit,
    output logic              perr,
    output srx_end_e          kind
);
    logic all_low;

    // Parity compare and frame-ending classification
    always_comb begin
        perr    = par_en && ((^data ^ par_bit) != par_odd);
        all_low = (data == '0) && !(par_en && par_bit);
        if (stop_bit)     kind = END_OK;
        else if (all_low) kind = END_BREAK;
        else              kind = END_FRAME;
    end
endmodule

// File: rtl/srx_brk_flag.sv
// Module: srx_brk_flag
// Sticky change-of-break flag. It is set by a break event and cleared by command,
// and set wins when both arrive together.
// Assumes: brk_evt is a single-cycle pulse.
module srx_brk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_evt,
    input  logic clr,
    output logic brk_chg
);
    // Hold the flag until cleared; a simultaneous break re-sets it
    always_ff @(posedge clk) begin
        if (!rst_n)       brk_chg <= 1'b0;
        else if (brk_evt) brk_chg <= 1'b1;
        else if (clr)     brk_chg <= 1'b0;
    end

    AST_CHG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> brk_chg); // R9
    AST_CHG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_chg && !clr && !brk_evt) |=> brk_chg); // R9
endmodule

// File: rtl/srx_core.sv
// Module: srx_core
// Start validation, bit-centre sampling, framing-error resync and break wait.
// Assumes: line is synchronized; tick is a one-cycle pulse at OVS times the bit rate.
module srx_core
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              line,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              char_wr,
    output logic [DATA_W-1:0] char_data,
    output logic              char_perr,
    output logic              char_ferr,
    output logic              char_brk,
    output logic              brk_evt
);
    localparam int CNT_W      = $clog2(OVS);
    localparam int HALF       = OVS / 2;
    localparam int START_LAST = HALF - 2;
    localparam int FE_LAST    = HALF - 1;
    localparam int BIT_LAST   = OVS - 1;
    localparam int IDX_W      = $clog2(DATA_W + 3);
    localparam int SEL_W      = $clog2(DATA_W);
    localparam int MIN_BITS   = DATA_W - (1 << LEN_W) + 1;

    srx_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shdata;
    logic              par_bit;
    logic              seen_hi;
    logic              hi_run;

    logic [IDX_W-1:0]  nbits;
    logic [IDX_W-1:0]  frame_last;
    logic              at_center;
    logic              at_stop;
    logic              perr;
    srx_end_e          kind;

    // Frame geometry and bit-centre strobes
    always_comb begin
        nbits      = IDX_W'(MIN_BITS) + IDX_W'(len_sel);
        frame_last = nbits + IDX_W'(par_en);
        at_center  = tick && rx_en && (state == ST_BITS) && (cnt == CNT_W'(BIT_LAST));
        at_stop    = at_center && (idx == frame_last);
    end

    srx_frame_chk #(.DATA_W(DATA_W)) u_chk (
        .data     (shdata),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .par_bit  (par_bit),
        .stop_bit (line),
        .perr     (perr),
        .kind     (kind)
    );

    assign brk_evt = at_stop && (kind == END_BREAK);

    // Receiver sequencer, advanced on oversampling ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            cnt       <= '0;
            idx       <= '0;
            shdata    <= '0;
            par_bit   <= 1'b0;
            seen_hi   <= 1'b0;
            hi_run    <= 1'b0;
            char_wr   <= 1'b0;
            char_data <= '0;
            char_perr <= 1'b0;
            char_ferr <= 1'b0;
            char_brk  <= 1'b0;
        end else begin
            char_wr <= 1'b0;
            if (!rx_en) begin
                state   <= ST_HUNT;
                seen_hi <= 1'b0;
            end else if (tick) begin
                unique case (state)
                    ST_HUNT: begin
                        seen_hi <= line;
                        if (seen_hi && !line) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == CNT_W'(START_LAST)) begin
                            cnt <= '0;
                            if (line) begin
                                state   <= ST_HUNT;
                                seen_hi <= 1'b1;
                            end else begin
                                state  <= ST_BITS;
                                idx    <= '0;
                                shdata <= '0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BITS: begin
                        if (cnt == CNT_W'(BIT_LAST)) begin
                            cnt <= '0;
                            idx <= idx + 1'b1;
                            if (idx < nbits) begin
                                shdata[idx[SEL_W-1:0]] <= line;
                            end else if (!at_stop) begin
                                par_bit <= line;
                            end
                            if (at_stop) begin
                                char_wr   <= 1'b1;
                                char_data <= (kind == END_BREAK) ? '0 : shdata;
                                char_perr <= (kind != END_BREAK) && perr;
                                char_ferr <= (kind == END_FRAME);
                                char_brk  <= (kind == END_BREAK);
                                unique case (kind)
                                    END_OK: begin
                                        state   <= ST_HUNT;
                                        seen_hi <= 1'b1;
                                    end
                                    END_BREAK: begin
                                        state  <= ST_BRKWAIT;
                                        hi_run <= 1'b0;
                                    end
                                    default: begin
                                        state <= ST_FEHOLD;
                                    end
                                endcase
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_FEHOLD: begin
                        if (cnt == CNT_W'(FE_LAST)) begin
                            cnt <= '0;
                            if (!line) begin
                                state <= ST_START;
                            end else begin
                                state   <= ST_HUNT;
                                seen_hi <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BRKWAIT: begin
                        if (line) begin
                            if (hi_run) begin
                                state   <= ST_HUNT;
                                seen_hi <= 1'b1;
                            end
                            hi_run <= 1'b1;
                        end else begin
                            hi_run <= 1'b0;
                        end
                    end
                    default: begin
                        state <= ST_HUNT;
                    end
                endcase
            end
        end
    end

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        char_wr |=> !char_wr); // R4
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        char_wr |-> ((char_data >> (MIN_BITS + int'(len_sel))) == '0)); // R2
    AST_BRK_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (char_wr && char_brk) |-> (char_data == '0 && !char_ferr && !char_perr)); // R7
    AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !char_wr); // R10
    AST_BRK_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRKWAIT && tick && rx_en && !line) |=> (state == ST_BRKWAIT)); // R8
endmodule

// File: rtl/serial_char_rx.sv
// Module: serial_char_rx
// Top of the serial character receiver: synchronizer, sequencer and break flag.
// Assumes: os_tick is a single-cycle pulse at 16x the bit rate, and the
// configuration inputs only change while the line is idle.
module serial_char_rx #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int LEN_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_en,
    input  logic              rx_line,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              brk_chg_clr,
    output logic              char_wr,
    output logic [DATA_W-1:0] char_data,
    output logic              char_perr,
    output logic              char_ferr,
    output logic              char_brk,
    output logic              brk_chg
);
    logic line_s;
    logic brk_evt;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (line_s)
    );

    srx_core #(.DATA_W(DATA_W), .OVS(OVS), .LEN_W(LEN_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .rx_en     (rx_en),
        .line      (line_s),
        .len_sel   (len_sel),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .char_wr   (char_wr),
        .char_data (char_data),
        .char_perr (char_perr),
        .char_ferr (char_ferr),
        .char_brk  (char_brk),
        .brk_evt   (brk_evt)
    );

    srx_brk_flag u_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .brk_evt (brk_evt),
        .clr     (brk_chg_clr),
        .brk_chg (brk_chg)
    );

    AST_BRK_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (char_wr && char_brk) |-> brk_chg); // R9
endmodule

// File: tb/serial_char_rx_bench.sv
`timescale 1ns/1ps
module serial_char_rx_bench;
    localparam int TDIV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rx_en = 1'b0;
    logic rx_line = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic par_en = 1'b0;
    logic par_odd = 1'b0;
    logic brk_chg_clr = 1'b0;
    logic char_wr, char_perr, char_ferr, char_brk, brk_chg;
    logic [7:0] char_data;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 0;
    bit finished = 0;
    string cur_req = "R11";
    logic [10:0] gotq[$];
    int coincide = 0;

    always #2.5 clk = ~clk;

    serial_char_rx u_serial_char_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en), .rx_line(rx_line),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .brk_chg_clr(brk_chg_clr),
        .char_wr(char_wr), .char_data(char_data), .char_perr(char_perr),
        .char_ferr(char_ferr), .char_brk(char_brk), .brk_chg(brk_chg)
    );

    // Oversampling tick: one pulse every TDIV clocks
    int tdiv = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv = 0; os_tick <= 1'b0;
        end else if (tdiv == TDIV - 1) begin
            tdiv = 0; os_tick <= 1'b1;
        end else begin
            tdiv++; os_tick <= 1'b0;
        end
    end

    // Behavioural reference model, one step per clock
    int m_mode, m_cnt, m_idx, m_seen, m_hirun;
    bit m_s1 = 1, m_s2 = 1;
    bit m_bits[16];
    bit m_wr, m_pe, m_fe, m_bk, m_chg;
    logic [7:0] m_d;
    always @(posedge clk) begin
        bit l, pb, brk_ev;
        int nb, fl;
        logic [7:0] dv;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_idx = 0; m_seen = 0; m_hirun = 0;
            m_s1 = 1; m_s2 = 1; m_wr = 0; m_pe = 0; m_fe = 0; m_bk = 0; m_chg = 0; m_d = 0;
        end else begin
            l = m_s2; m_s2 = m_s1; m_s1 = rx_line; m_wr = 0; brk_ev = 0;
            nb = 5 + int'(len_sel);
            fl = nb + (par_en ? 1 : 0) + 1;
            if (!rx_en) begin
                m_mode = 0; m_seen = 0;
            end else if (os_tick) begin
                case (m_mode)
                    0: begin
                        if (m_seen != 0 && !l) begin m_mode = 1; m_cnt = 0; end
                        m_seen = l;
                    end
                    1: begin
                        m_cnt++;
                        if (m_cnt == 7) begin
                            if (l) begin m_mode = 0; m_seen = 1; end
                            else begin m_mode = 2; m_cnt = 0; m_idx = 0; end
                        end
                    end
                    2: begin
                        m_cnt++;
                        if (m_cnt == 16) begin
                            m_cnt = 0; m_bits[m_idx] = l; m_idx++;
                            if (m_idx == fl) begin
                                dv = 0;
                                for (int i = 0; i < nb; i++) dv[i] = m_bits[i];
                                pb = par_en ? m_bits[nb] : 1'b0;
                                m_wr = 1;
                                m_pe = par_en && ((^dv ^ pb) != par_odd);
                                if (l) begin
                                    m_d = dv; m_fe = 0; m_bk = 0; m_mode = 0; m_seen = 1;
                                end else if (dv == 0 && !pb) begin
                                    m_d = 0; m_pe = 0; m_fe = 0; m_bk = 1; brk_ev = 1;
                                    m_mode = 4; m_hirun = 0;
                                end else begin
                                    m_d = dv; m_fe = 1; m_bk = 0; m_mode = 3; m_cnt = 0;
                                end
                            end
                        end
                    end
                    3: begin
                        m_cnt++;
                        if (m_cnt == 8) begin
                            if (!l) begin m_mode = 1; m_cnt = 0; end
                            else begin m_mode = 0; m_seen = 1; end
                        end
                    end
                    default: begin
                        if (l) begin
                            m_hirun++;
                            if (m_hirun == 2) begin m_mode = 0; m_seen = 1; end
                        end else m_hirun = 0;
                    end
                endcase
            end
            if (brk_chg_clr) m_chg = 0;
            if (brk_ev) m_chg = 1;
        end
    end

    // Per-clock comparison against the model, plus strobe capture
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            n_chk++;
            if (char_wr !== m_wr || brk_chg !== m_chg ||
                (m_wr && ({char_brk, char_ferr, char_perr, char_data} !== {m_bk, m_fe, m_pe, m_d}))) begin
                n_fail++;
                $display("FAIL %s per-cycle: actual wr=%0b chg=%0b b/f/p=%0b%0b%0b d=%h expected wr=%0b chg=%0b b/f/p=%0b%0b%0b d=%h",
                         cur_req, char_wr, brk_chg, char_brk, char_ferr, char_perr, char_data,
                         m_wr, m_chg, m_bk, m_fe, m_pe, m_d);
            end
            if (char_wr) gotq.push_back({char_brk, char_ferr, char_perr, char_data});
            if (char_wr && char_brk && brk_chg) coincide++;
        end
    end

    task automatic check(input string req, input bit ok, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_q(input string req, input logic [10:0] expq[$]);
        check(req, gotq.size() == expq.size(), "strobe count", gotq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < gotq.size(); i++)
            check(req, gotq[i] === expq[i], "brk/ferr/perr/data", int'(gotq[i]), int'(expq[i]));
        gotq.delete();
    endtask

    task automatic hold(input logic lvl, input int nt);
        rx_line = lvl;
        repeat (nt * TDIV) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit hp, input bit pb,
                        input bit stp, input int stop_ticks);
        hold(1'b0, 16);
        for (int i = 0; i < nb; i++) hold(d[i], 16);
        if (hp) hold(pb, 16);
        hold(stp, stop_ticks);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired in %s: actual running expected finished", cur_req);
            summary();
            $finish;
        end
    end

    initial begin
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        cur_req = "R11";
        check("R11", char_wr === 1'b0, "char_wr in reset", int'(char_wr), 0);
        check("R11", brk_chg === 1'b0, "brk_chg in reset", int'(brk_chg), 0);
        rst_n = 1'b1; rx_en = 1'b1; cmp_on = 1;
        hold(1'b0, 40);   // low line at reset release is no start
        check("R11", gotq.size() == 0, "strobes with low line after reset", gotq.size(), 0);
        hold(1'b1, 20);

        cur_req = "R4";   // back-to-back 8N characters
        send(8'hA5, 8, 0, 0, 1, 16);
        send(8'h3C, 8, 0, 0, 1, 16);
        hold(1'b1, 30);
        chk_q("R4", '{11'h0A5, 11'h03C});

        cur_req = "R2";   // 5-bit length, upper bits zero
        len_sel = 2'd0;
        send(8'hF3, 5, 0, 0, 1, 16);
        hold(1'b1, 30);
        chk_q("R2", '{11'h013});
        len_sel = 2'd3;

        cur_req = "R3";   // parity even and odd
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h55, 8, 1, 0, 1, 16);
        send(8'h55, 8, 1, 1, 1, 16);
        hold(1'b1, 20);
        par_odd = 1'b1;
        send(8'h07, 8, 1, 0, 1, 16);
        send(8'h07, 8, 1, 1, 1, 16);
        hold(1'b1, 30);
        chk_q("R3", '{11'h055, 11'h155, 11'h007, 11'h107});
        par_en = 1'b0; par_odd = 1'b0;

        cur_req = "R1";   // short low glitch rejected
        hold(1'b0, 3);
        hold(1'b1, 30);
        send(8'hC3, 8, 0, 0, 1, 16);
        hold(1'b1, 30);
        chk_q("R1", '{11'h0C3});

        cur_req = "R6";   // framing error, line stays low: resync
        send(8'h81, 8, 0, 0, 0, 16);
        send(8'h5A, 8, 0, 0, 1, 16);
        hold(1'b1, 30);
        chk_q("R6", '{11'h281, 11'h05A});

        cur_req = "R5";   // framing error, line returns high
        send(8'h81, 8, 0, 0, 0, 10);
        hold(1'b1, 30);
        send(8'h11, 8, 0, 0, 1, 16);
        hold(1'b1, 30);
        chk_q("R5", '{11'h281, 11'h011});

        cur_req = "R8";   // break, single high tick ignored
        hold(1'b0, 16 * 11);
        hold(1'b1, 1);
        hold(1'b0, 20);
        hold(1'b1, 20);
        send(8'h42, 8, 0, 0, 1, 16);
        hold(1'b1, 30);
        chk_q("R7", '{11'h400, 11'h042});
        check("R9", brk_chg === 1'b1, "brk_chg after break", int'(brk_chg), 1);
        brk_chg_clr = 1'b1; @(negedge clk); brk_chg_clr = 1'b0; @(negedge clk);
        check("R9", brk_chg === 1'b0, "brk_chg after clear", int'(brk_chg), 0);

        cur_req = "R9";   // clear held across the break strobe edge
        coincide = 0;
        brk_chg_clr = 1'b1;
        hold(1'b0, 16 * 11);
        hold(1'b1, 20);
        brk_chg_clr = 1'b0;
        @(negedge clk);
        check("R9", coincide == 1, "break strobe with flag set", coincide, 1);
        check("R9", brk_chg === 1'b0, "flag after held clear", int'(brk_chg), 0);
        chk_q("R9", '{11'h400});

        cur_req = "R10";  // disabled receiver ignores a frame
        rx_en = 1'b0;
        send(8'h99, 8, 0, 0, 1, 16);
        hold(1'b1, 10);
        rx_en = 1'b1;
        hold(1'b1, 30);
        chk_q("R10", '{});
        send(8'h24, 8, 0, 0, 1, 16);
        hold(1'b1, 30);
        chk_q("R10", '{11'h024});

        finished = 1;
        summary();
        $finish;
    end
endmodule